// File: doc/BRIEF.md
# Warm-Reset Sequencer with Destination Input Gating

This block lets a group of registers that is cleared only at power-on sit next to a group that is cleared by a warm (functional) reset, in the same clock domain, without the warm reset corrupting the power-on group. An asynchronous warm-reset request is first brought into the clock domain by a two-flop synchronizer that is itself cleared only by power-on reset. A rising edge of the synchronized request starts a sequence. The sequence raises an early warning at once, applies the source reset a fixed number of cycles later, holds that reset for a minimum width, and then waits one settling cycle.

From the first warning cycle until the settling cycle ends, a gate blocks the load input of the destination register, so the destination keeps its contents while the source register changes because of the reset. The source register, the gated destination register and an optional capture flop on the destination output are part of the block. A busy output shows that a sequence is in progress. A sticky flag, cleared only by power-on reset or by an explicit clear input, records that a warm reset has taken place.

Power-on reset (`por`) is synchronous and active high.

Top module: `warm_rst_guard`

## Requirements
- R1: While `por` is high, and after at least one clock edge, `warn`=0, `busy`=0, `src_rst`=1, `gate_closed`=1, `src_q`=0, `dst_q`=0 and `warm_seen`=0.
- R2: The request passes through two synchronizer flops and an edge register. If `warm_req_async` rises and is sampled high at clock edge k, `warn` is high after edge k+2. A request held high starts only one sequence.
- R3: `src_rst` rises exactly DELAY cycles after `warn` rises (the default is 2). `warn` stays high until `src_rst` falls.
- R4: Within a sequence, `src_rst` stays high for exactly MIN_RST cycles (the default is 4, and values below 4 are raised to 4). It falls on a clock edge.
- R5: `gate_closed` is high from the first `warn` cycle through exactly one cycle after `src_rst` falls. It then drops at the same edge as `busy`.
- R6: While `gate_closed` is high, `dst_load` has no effect and the destination keeps its value. A warm reset never clears the destination.
- R7: The source register loads `src_wr_data` when `src_wr_en` is high, and clears to 0 at every edge at which `src_rst` is high.
- R8: While the gate is open, `dst_load` captures `src_q` into the destination register. With OUT_FLOP=1 (the default), the captured value appears on `dst_q` one cycle later than it would with OUT_FLOP=0.
- R9: Request edges that occur while a sequence is active are ignored. No new sequence starts after the current one returns to idle.
- R10: `busy` is high exactly while a sequence is active, which covers the warning, source-reset and settling cycles.
- R11: `warm_seen` is set at the edge where a sequence starts. It stays set until an edge with `warm_seen_clr` high. If a start and a clear fall on the same edge, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source and destination registers |
| por | input | 1 | Power-on reset, synchronous, active high |
| warm_req_async | input | 1 | Asynchronous warm-reset request; a rising edge starts a sequence |
| src_wr_en | input | 1 | Write enable of the source register |
| src_wr_data | input | W | Write data of the source register |
| dst_load | input | 1 | Capture request for the destination register |
| warm_seen_clr | input | 1 | Clears the sticky warm-reset flag |
| src_q | output | W | Source register contents |
| dst_q | output | W | Destination register output, delayed by the optional capture flop |
| warn | output | 1 | Early warning, high from sequence start until the source reset ends |
| src_rst | output | 1 | Reset applied to the source register |
| gate_closed | output | 1 | High while destination loads are blocked |
| busy | output | 1 | A warm-reset sequence is in progress |
| warm_seen | output | 1 | Sticky record that a warm reset occurred |

## Verification
The bench measures the distances between the rise of `warn`, the rise and fall of `src_rst`, and the release of the gate. A wrong counter load would move `src_rst` by one cycle or shorten the reset pulse. An early gate release would let the destination capture the source while the source is still being cleared. It holds `dst_load` high for the whole sequence to catch a gate that leaks, which would show up as the destination dropping to zero. It pulses and holds the request during a sequence to catch a design that restarts, which would show up as a second `busy` period. Random traffic with occasional power-on resets is compared cycle by cycle with a bench model. This comparison catches a wrong set-versus-clear priority on the sticky flag and a missing or extra capture-flop cycle.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WARN   = 2'd1,
        SQ_HOLD   = 2'd2,
        SQ_SETTLE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic warn;
        logic src_rst;
        logic gate;
        logic busy;
    } seq_ctrl_t;

    // Width needed to count down from (larger of a, b) - 1 to zero.
    function automatic int cnt_width(int a, int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

    function automatic seq_ctrl_t decode_ctrl(seq_state_e st, logic por);
        seq_ctrl_t c;
        c.warn    = (st == SQ_WARN) || (st == SQ_HOLD);
        c.src_rst = por || (st == SQ_HOLD);
        c.gate    = por || (st != SQ_IDLE);
        c.busy    = (st != SQ_IDLE);
        return c;
    endfunction

endpackage

// File: rtl/wrg_sync.sv
module wrg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (por) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (por) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wrg_seq.sv
module wrg_seq
    import wrg_pkg::*;
#(
    parameter int DLY  = 2,
    parameter int HOLD = 4
) (
    input  logic      clk,
    input  logic      por,
    input  logic      req_sync,
    output logic      start,
    output seq_ctrl_t ctrl
);
    localparam int CW = cnt_width(DLY, HOLD);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          req_d;

    assign start = req_sync && !req_d && (state == SQ_IDLE);
    assign ctrl  = decode_ctrl(state, por);

    always_ff @(posedge clk) begin
        if (por) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            req_d <= 1'b0;
        end else begin
            req_d <= req_sync;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_WARN;
                        cnt   <= CW'(DLY - 1);
                    end
                end
                SQ_WARN: begin
                    if (cnt == '0) begin
                        state <= SQ_HOLD;
                        cnt   <= CW'(HOLD - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (cnt == '0) state <= SQ_SETTLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wrg_src_reg.sv
module wrg_src_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         src_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (src_rst)    q <= '0;
        else if (wr_en) q <= wr_data;
    end
endmodule

// File: rtl/wrg_dst_bank.sv
module wrg_dst_bank #(
    parameter int W        = 8,
    parameter bit OUT_FLOP = 1'b1
) (
    input  logic         clk,
    input  logic         por,
    input  logic         gate,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] bank_q,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (por)                bank_q <= '0;
        else if (load && !gate) bank_q <= din;
    end

    if (OUT_FLOP) begin : g_cap
        logic [W-1:0] cap_q;
        always_ff @(posedge clk) begin
            if (por) cap_q <= '0;
            else     cap_q <= bank_q;
        end
        assign dout = cap_q;
    end else begin : g_pass
        assign dout = bank_q;
    end
endmodule

// File: rtl/warm_rst_guard.sv
module warm_rst_guard
    import wrg_pkg::*;
#(
    parameter int W        = 8,
    parameter int DELAY    = 2,
    parameter int MIN_RST  = 4,
    parameter bit OUT_FLOP = 1'b1
) (
    input  logic         clk,
    input  logic         por,
    input  logic         warm_req_async,
    input  logic         src_wr_en,
    input  logic [W-1:0] src_wr_data,
    input  logic         dst_load,
    input  logic         warm_seen_clr,
    output logic [W-1:0] src_q,
    output logic [W-1:0] dst_q,
    output logic         warn,
    output logic         src_rst,
    output logic         gate_closed,
    output logic         busy,
    output logic         warm_seen
);
    localparam int DLY  = (DELAY < 1) ? 1 : DELAY;
    localparam int HOLD = (MIN_RST < 4) ? 4 : MIN_RST;

    logic      req_sync;
    logic      seq_start;
    seq_ctrl_t ctrl;
    logic [W-1:0] bank_q;

    wrg_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .por (por),
        .din (warm_req_async),
        .dout(req_sync)
    );

    wrg_seq #(.DLY(DLY), .HOLD(HOLD)) u_seq (
        .clk     (clk),
        .por     (por),
        .req_sync(req_sync),
        .start   (seq_start),
        .ctrl    (ctrl)
    );

    assign warn        = ctrl.warn;
    assign src_rst     = ctrl.src_rst;
    assign gate_closed = ctrl.gate;
    assign busy        = ctrl.busy;

    wrg_src_reg #(.W(W)) u_src (
        .clk    (clk),
        .src_rst(src_rst),
        .wr_en  (src_wr_en),
        .wr_data(src_wr_data),
        .q      (src_q)
    );

    wrg_dst_bank #(.W(W), .OUT_FLOP(OUT_FLOP)) u_dst (
        .clk   (clk),
        .por   (por),
        .gate  (gate_closed),
        .load  (dst_load),
        .din   (src_q),
        .bank_q(bank_q),
        .dout  (dst_q)
    );

    always_ff @(posedge clk) begin
        if (por)                warm_seen <= 1'b0;
        else if (seq_start)     warm_seen <= 1'b1;
        else if (warm_seen_clr) warm_seen <= 1'b0;
    end
endmodule

// File: rtl/wrg_checker.sv
module wrg_checker #(
    parameter int W    = 8,
    parameter int DLY  = 2,
    parameter int HOLD = 4
) (
    input logic         clk,
    input logic         por,
    input logic         warn,
    input logic         src_rst,
    input logic         gate_closed,
    input logic         busy,
    input logic         warm_seen,
    input logic [W-1:0] bank_q
);
    int warn_cnt;
    int rst_cnt;

    always_ff @(posedge clk) begin
        if (por) begin
            warn_cnt <= 0;
            rst_cnt  <= 0;
        end else begin
            if (!warn)                warn_cnt <= 0;
            else if (!src_rst)        warn_cnt <= warn_cnt + 1;
            if (src_rst)              rst_cnt  <= rst_cnt + 1;
            else                      rst_cnt  <= 0;
        end
    end

    AST_RST_LEAD: assert property (@(posedge clk) disable iff (por)
        $rose(src_rst) |-> (warn && warn_cnt == DLY)); // R3

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (por)
        ($fell(src_rst) && !$past(por)) |-> (rst_cnt == HOLD)); // R4

    AST_GATE_SETTLE: assert property (@(posedge clk) disable iff (por)
        ($fell(src_rst) && !$past(por)) |-> (gate_closed && !warn)); // R5

    AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (por)
        ($fell(src_rst) && !$past(por)) |=> !gate_closed); // R5

    AST_DST_HOLD: assert property (@(posedge clk) disable iff (por)
        gate_closed |=> $stable(bank_q)); // R6

    AST_WARN_BUSY: assert property (@(posedge clk) disable iff (por)
        warn |-> busy); // R10

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (por)
        $rose(busy) |-> warm_seen); // R11
endmodule

bind warm_rst_guard wrg_checker #(.W(W), .DLY(DLY), .HOLD(HOLD)) u_chk (
    .clk        (clk),
    .por        (por),
    .warn       (warn),
    .src_rst    (src_rst),
    .gate_closed(gate_closed),
    .busy       (busy),
    .warm_seen  (warm_seen),
    .bank_q     (bank_q)
);

// File: tb/warm_rst_guard_test.sv
module warm_rst_guard_test;
    localparam int W = 8;
    localparam int D = 2;
    localparam int H = 4;

    logic         clk = 1'b0;
    logic         por = 1'b1;
    logic         req = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         load = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] src_q, dst_q;
    logic         warn, src_rst, gate_closed, busy, warm_seen;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    warm_rst_guard uut (
        .clk(clk), .por(por), .warm_req_async(req),
        .src_wr_en(wr_en), .src_wr_data(wr_data), .dst_load(load),
        .warm_seen_clr(clr), .src_q(src_q), .dst_q(dst_q),
        .warn(warn), .src_rst(src_rst), .gate_closed(gate_closed),
        .busy(busy), .warm_seen(warm_seen)
    );

    // Reference model built from the requirements
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int   m_t = -1;
    logic [W-1:0] m_src = '0, m_bank = '0, m_dq = '0;
    logic m_seen = 0;

    function automatic logic e_warn(int t);    return t >= 0 && t < D + H; endfunction
    function automatic logic e_rst(int t);     return t >= D && t < D + H; endfunction

    always @(posedge clk) begin
        logic st;
        if (por) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_t = -1;
            m_src = '0; m_bank = '0; m_dq = '0; m_seen = 0;
        end else begin
            st = m_s2 && !m_s3 && (m_t == -1);
            m_dq = m_bank;
            if (load && !(m_t >= 0)) m_bank = m_src;
            if (e_rst(m_t)) m_src = '0;
            else if (wr_en) m_src = wr_data;
            if (st) m_seen = 1;
            else if (clr) m_seen = 0;
            if (st) m_t = 0;
            else if (m_t >= 0) m_t = (m_t == D + H) ? -1 : m_t + 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = req;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2 warn", warn, e_warn(m_t));
        chk("R4 src_rst", src_rst, por | e_rst(m_t));
        chk("R5 gate_closed", gate_closed, por | (m_t >= 0));
        chk("R10 busy", busy, m_t >= 0);
        chk("R7 src_q", src_q, m_src);
        chk("R6 dst_q", dst_q, m_dq);
        chk("R11 warm_seen", warm_seen, m_seen);
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w_r, r_r, r_f, g_f, rises;
        logic pb;
        void'($urandom(32'h5EED_0042));
        // R1: power-on state
        repeat (3) cyc();
        chk("R1 warn", warn, 0);
        chk("R1 busy", busy, 0);
        chk("R1 src_rst", src_rst, 1);
        chk("R1 gate", gate_closed, 1);
        chk("R1 dst_q", dst_q, 0);
        chk("R1 warm_seen", warm_seen, 0);
        por = 0;
        cyc();
        // R7 / R8: capture path and output flop latency
        wr_en = 1; wr_data = 8'h5A;
        cyc();
        chk("R7 src write", src_q, 8'h5A);
        wr_en = 0; load = 1;
        cyc();
        chk("R8 capture latency", dst_q, 8'h00);
        load = 0;
        cyc();
        chk("R8 capture visible", dst_q, 8'h5A);
        // Directed warm reset with loads held high during it
        wr_en = 1; wr_data = 8'h3C;
        cyc();
        wr_en = 0; load = 1;
        repeat (2) cyc();
        load = 0;
        chk("R8 setup", dst_q, 8'h3C);
        req = 1;
        w_r = -1; r_r = -1; r_f = -1; g_f = -1; pb = 0;
        for (int k = 1; k <= 16; k++) begin
            cyc();
            if (k == 1) req = 0;
            if (k == 4) req = 1;   // R9: edge during active sequence
            if (k == 5) req = 0;
            if (warn && w_r < 0) w_r = k;
            if (src_rst && r_r < 0) r_r = k;
            if (!src_rst && r_r >= 0 && r_f < 0) r_f = k;
            if (!gate_closed && pb && g_f < 0) g_f = k;
            if (busy) begin
                chk("R6 dst hold", dst_q, 8'h3C);
                load = 1; wr_en = 1; wr_data = 8'($urandom);
            end else if (pb) begin
                load = 0; wr_en = 0;
            end
            pb = busy;
        end
        load = 0; wr_en = 0;
        chk("R2 warn delay", w_r, 3);
        chk("R3 warn to rst", r_r - w_r, D);
        chk("R4 rst width", r_f - r_r, H);
        chk("R5 gate release", g_f - r_f, 1);
        chk("R11 flag set", warm_seen, 1);
        repeat (6) cyc();
        chk("R9 no restart", busy, 0);
        clr = 1;
        cyc();
        clr = 0;
        chk("R11 flag clear", warm_seen, 0);
        // R9: request held high starts one sequence only
        req = 1; rises = 0; pb = 0;
        for (int k = 0; k < 25; k++) begin
            cyc();
            if (busy && !pb) rises++;
            pb = busy;
        end
        req = 0;
        chk("R9 held request", rises, 1);
        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            cyc();
            wr_en   = 1'($urandom % 2);
            wr_data = 8'($urandom);
            load    = ($urandom % 3) == 0;
            clr     = ($urandom % 16) == 0;
            por     = ($urandom % 600) == 0;
            if (($urandom % 30) == 0) req = ~req;
        end
        por = 0;
        repeat (20) cyc();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule